// File: doc/BRIEF.md
# Reserve-Way Tag Directory

This block is a side tag table for a set-associative cache whose sets are grouped into fellow groups. The top few ways of every set form a reserve region, and a heavily written set may move a block into the reserve ways of another set in its own group. The directory remembers which tag sits in each reserve way. A request can then find a moved block in parallel with the normal lookup in its home set. One directory set covers one group, so a lookup from any member set scans the reserve ways of every member.

The directory has `SETS/GROUP` sets of `RSV*GROUP` ways. Each directory slot is tied by fixed arithmetic to exactly one reserve way of one member set. Directory set `i`, way `j` stands for cache set `(j/RSV)*(SETS/GROUP)+i` and cache way `(WAYS-RSV)+(j mod RSV)`. The reverse mapping goes from cache set `u` and way `v` to directory set `u mod (SETS/GROUP)` and way `(u/(SETS/GROUP))*RSV + v-(WAYS-RSV)`.

Commands use cache coordinates throughout. The controller can look up a tag, insert a redirected block's tag, and drop an entry. On every cycle it also gets a placement suggestion for the reserve ways of a chosen target set. A free way is suggested when one exists. Otherwise the least recently used way is suggested, with a write-back flag and the tag being displaced.

Top module: `rpd_dir`

## Requirements
- R1: While `rst` is high at a clock edge, every output registers zero. After reset every entry is invalid: every lookup misses, and for any target set the suggestion is that set's lowest reserve way (`WAYS-RSV`) with `vic_wb` low.
- R2: Lookup results register on the clock edge that samples the request. A block inserted for cache set u is found from any requesting set whose index mod `SETS/GROUP` equals u mod `SETS/GROUP`. Requests from other groups miss.
- R3: On a hit, `hit_set` and `hit_way` give the cache set and cache way that the matching directory slot stands for. These are the same coordinates the block was inserted with. On a miss both outputs are zero.
- R4: An insert at cache set u and reserve way v makes that one directory slot valid with the new tag, replacing any tag that was there before.
- R5: An invalidate at cache set u and reserve way v makes that slot invalid. When an insert and an invalidate name the same slot in the same cycle, the insert wins.
- R6: An insert or invalidate whose way is below `WAYS-RSV` has no effect on any entry.
- R7: A lookup and an insert in the same directory set in the same cycle are ordered lookup first, so the lookup does not see the inserted tag.
- R8: When any reserve way of target set `vq_set` is invalid, the suggestion is the lowest-numbered such way, and `vic_wb` and `vic_tag` are zero.
- R9: When all reserve ways of the target set are valid, the suggestion is the least recently touched of them. `vic_wb` is high and `vic_tag` is that way's tag. Both an insert and a lookup hit count as a touch.
- R10: A lookup hit makes its slot the most recently touched.
- R11: With `lk_valid` low, `hit` stays low and recency order does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | $clog2(SETS) | Home cache set of the lookup |
| lk_tag | input | TAG_W | Tag to find |
| ins_valid | input | 1 | Insert command |
| ins_set | input | $clog2(SETS) | Cache set whose reserve way receives the block |
| ins_way | input | $clog2(WAYS) | Cache way receiving the block |
| ins_tag | input | TAG_W | Tag to store |
| inv_valid | input | 1 | Invalidate command |
| inv_set | input | $clog2(SETS) | Cache set of the entry to drop |
| inv_way | input | $clog2(WAYS) | Cache way of the entry to drop |
| vq_set | input | $clog2(SETS) | Target set for the placement suggestion |
| hit | output | 1 | Lookup found the tag in a reserve way |
| hit_set | output | $clog2(SETS) | Cache set holding the found block |
| hit_way | output | $clog2(WAYS) | Cache way holding the found block |
| vic_set | output | $clog2(SETS) | Target set of the suggestion |
| vic_way | output | $clog2(WAYS) | Suggested reserve way |
| vic_wb | output | 1 | Suggested way is occupied; write back before reuse |
| vic_tag | output | TAG_W | Tag being displaced when `vic_wb` is high |

## Verification
Two pairs of functions can coincide. A lookup can arrive together with an insert into the same directory set. An insert can arrive together with an invalidate of the same slot. The bench provokes the first pair by inserting a tag and looking it up from another member of the same group in one cycle. The lookup must miss in that cycle and hit in the next one. It provokes the second pair by driving both commands at one slot in one cycle. A following lookup must still find the tag. Recency is judged at the ports by watching which way the placement suggestion names after inserts, hits and idle lookups.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    typedef int unsigned uint_t;

    // Directory slot -> cache set
    function automatic uint_t dir_to_cset(uint_t dset, uint_t dway, uint_t rsv, uint_t dsets);
        return (dway / rsv) * dsets + dset;
    endfunction

    // Directory slot -> cache way
    function automatic uint_t dir_to_cway(uint_t dway, uint_t rsv, uint_t ways);
        return (ways - rsv) + (dway % rsv);
    endfunction

    // Cache set -> directory set
    function automatic uint_t c_to_dset(uint_t cset, uint_t dsets);
        return cset % dsets;
    endfunction

    // Cache set and reserve way -> directory way
    function automatic uint_t c_to_dway(uint_t cset, uint_t cway, uint_t rsv, uint_t dsets, uint_t ways);
        return (cset / dsets) * rsv + (cway - (ways - rsv));
    endfunction

endpackage

// File: rtl/rpd_match.sv
module rpd_match #(
    parameter int unsigned NW    = 8,
    parameter int unsigned TAG_W = 42,
    localparam int unsigned IW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [NW-1:0][TAG_W-1:0] tags,
    input  logic [NW-1:0]            vld,
    input  logic [TAG_W-1:0]         key,
    output logic                     any,
    output logic [IW-1:0]            idx
);
    logic [NW-1:0] eq;

    for (genvar k = 0; k < NW; k++) begin : g_cmp
        assign eq[k] = vld[k] && (tags[k] == key);
    end

    // lowest matching slot wins
    always_comb begin
        any = |eq;
        idx = '0;
        for (int k = NW - 1; k >= 0; k--) begin
            if (eq[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/rpd_age.sv
module rpd_age #(
    parameter int unsigned DSETS = 4,
    parameter int unsigned DWAYS = 8,
    localparam int unsigned AGE_W  = (DWAYS > 1) ? $clog2(DWAYS) : 1,
    localparam int unsigned DSET_W = (DSETS > 1) ? $clog2(DSETS) : 1
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   hit_en,
    input  logic [DSET_W-1:0]                      hit_ds,
    input  logic [AGE_W-1:0]                       hit_dw,
    input  logic                                   ins_en,
    input  logic [DSET_W-1:0]                      ins_ds,
    input  logic [AGE_W-1:0]                       ins_dw,
    output logic [DSETS-1:0][DWAYS-1:0][AGE_W-1:0] ages
);
    logic [DSETS-1:0][DWAYS-1:0][AGE_W-1:0] age_q, age_d;
    logic [DWAYS-1:0][AGE_W-1:0]            tmp;

    // make way w youngest; ways younger than it age by one
    function automatic logic [DWAYS-1:0][AGE_W-1:0] touch(
        input logic [DWAYS-1:0][AGE_W-1:0] a,
        input logic [AGE_W-1:0]            w
    );
        logic [DWAYS-1:0][AGE_W-1:0] r;
        for (int k = 0; k < DWAYS; k++) begin
            if (AGE_W'(k) == w)  r[k] = '0;
            else if (a[k] < a[w]) r[k] = a[k] + 1'b1;
            else                 r[k] = a[k];
        end
        return r;
    endfunction

    // a hit is applied before an insert in the same set
    always_comb begin
        age_d = age_q;
        tmp   = '0;
        for (int d = 0; d < DSETS; d++) begin
            tmp = age_q[d];
            if (hit_en && hit_ds == DSET_W'(d)) tmp = touch(tmp, hit_dw);
            if (ins_en && ins_ds == DSET_W'(d)) tmp = touch(tmp, ins_dw);
            age_d[d] = tmp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DSETS; d++)
                for (int k = 0; k < DWAYS; k++)
                    age_q[d][k] <= AGE_W'(k);
        end else begin
            age_q <= age_d;
        end
    end

    assign ages = age_q;

    p_touch_young_r9: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> age_q[$past(ins_ds)][$past(ins_dw)] == '0);
endmodule

// File: rtl/rpd_victim.sv
module rpd_victim #(
    parameter int unsigned NR    = 4,
    parameter int unsigned AGE_W = 3,
    localparam int unsigned RW   = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NR-1:0]              vld,
    input  logic [NR-1:0][AGE_W-1:0]   ages,
    output logic                       full,
    output logic [RW-1:0]              pick
);
    logic [AGE_W-1:0] best;

    always_comb begin
        full = &vld;
        pick = '0;
        best = ages[0];
        if (!full) begin
            for (int k = NR - 1; k >= 0; k--) begin
                if (!vld[k]) pick = RW'(k);
            end
        end else begin
            for (int k = 1; k < NR; k++) begin
                if (ages[k] > best) begin
                    best = ages[k];
                    pick = RW'(k);
                end
            end
        end
    end

    p_free_first_r8: assert property (@(posedge clk) disable iff (rst)
        !full |-> !vld[pick]);
endmodule

// File: rtl/rpd_dir.sv
module rpd_dir
    import rpd_pkg::*;
#(
    parameter int unsigned SETS  = 8,
    parameter int unsigned WAYS  = 16,
    parameter int unsigned RSV   = 4,
    parameter int unsigned GROUP = 2,
    parameter int unsigned TAG_W = 42,
    localparam int unsigned DSETS  = SETS / GROUP,
    localparam int unsigned DWAYS  = RSV * GROUP,
    localparam int unsigned SET_W  = $clog2(SETS),
    localparam int unsigned WAY_W  = $clog2(WAYS),
    localparam int unsigned DSET_W = (DSETS > 1) ? $clog2(DSETS) : 1,
    localparam int unsigned DWAY_W = (DWAYS > 1) ? $clog2(DWAYS) : 1,
    localparam int unsigned RSV_W  = (RSV > 1) ? $clog2(RSV) : 1,
    localparam int unsigned RBASE  = WAYS - RSV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             ins_valid,
    input  logic [SET_W-1:0] ins_set,
    input  logic [WAY_W-1:0] ins_way,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             inv_valid,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    input  logic [SET_W-1:0] vq_set,
    output logic             hit,
    output logic [SET_W-1:0] hit_set,
    output logic [WAY_W-1:0] hit_way,
    output logic [SET_W-1:0] vic_set,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_wb,
    output logic [TAG_W-1:0] vic_tag
);
    // storage
    logic [TAG_W-1:0] tag_q [DSETS][DWAYS];
    logic [DWAYS-1:0] vld_q [DSETS];

    // command decode into directory coordinates
    logic              ins_go, inv_go;
    logic [DSET_W-1:0] ins_ds, inv_ds, lk_ds, vq_ds;
    logic [DWAY_W-1:0] ins_dw, inv_dw, vq_base;

    assign ins_go  = ins_valid && (ins_way >= WAY_W'(RBASE));
    assign inv_go  = inv_valid && (inv_way >= WAY_W'(RBASE));
    assign ins_ds  = DSET_W'(c_to_dset(uint_t'(ins_set), DSETS));
    assign inv_ds  = DSET_W'(c_to_dset(uint_t'(inv_set), DSETS));
    assign lk_ds   = DSET_W'(c_to_dset(uint_t'(lk_set), DSETS));
    assign vq_ds   = DSET_W'(c_to_dset(uint_t'(vq_set), DSETS));
    assign ins_dw  = DWAY_W'(c_to_dway(uint_t'(ins_set), uint_t'(ins_way), RSV, DSETS, WAYS));
    assign inv_dw  = DWAY_W'(c_to_dway(uint_t'(inv_set), uint_t'(inv_way), RSV, DSETS, WAYS));
    assign vq_base = DWAY_W'(c_to_dway(uint_t'(vq_set), RBASE, RSV, DSETS, WAYS));

    // lookup across the whole group
    logic [DWAYS-1:0][TAG_W-1:0] row_tag;
    logic                        m_any;
    logic [DWAY_W-1:0]           m_idx;
    logic                        lk_hit;

    always_comb begin
        for (int k = 0; k < DWAYS; k++) row_tag[k] = tag_q[lk_ds][k];
    end

    rpd_match #(.NW(DWAYS), .TAG_W(TAG_W)) u_match (
        .tags (row_tag),
        .vld  (vld_q[lk_ds]),
        .key  (lk_tag),
        .any  (m_any),
        .idx  (m_idx)
    );

    assign lk_hit = lk_valid && m_any;

    // recency
    logic [DSETS-1:0][DWAYS-1:0][DWAY_W-1:0] ages;

    rpd_age #(.DSETS(DSETS), .DWAYS(DWAYS)) u_age (
        .clk    (clk),
        .rst    (rst),
        .hit_en (lk_hit),
        .hit_ds (lk_ds),
        .hit_dw (m_idx),
        .ins_en (ins_go),
        .ins_ds (ins_ds),
        .ins_dw (ins_dw),
        .ages   (ages)
    );

    // placement among the target set's own reserve ways
    logic [RSV-1:0]              sub_vld;
    logic [RSV-1:0][DWAY_W-1:0]  sub_age;
    logic [RSV-1:0][TAG_W-1:0]   sub_tag;
    logic                        v_full;
    logic [RSV_W-1:0]            v_pick;

    always_comb begin
        for (int k = 0; k < RSV; k++) begin
            sub_vld[k] = vld_q[vq_ds][vq_base + DWAY_W'(k)];
            sub_age[k] = ages[vq_ds][vq_base + DWAY_W'(k)];
            sub_tag[k] = tag_q[vq_ds][vq_base + DWAY_W'(k)];
        end
    end

    rpd_victim #(.NR(RSV), .AGE_W(DWAY_W)) u_victim (
        .clk  (clk),
        .rst  (rst),
        .vld  (sub_vld),
        .ages (sub_age),
        .full (v_full),
        .pick (v_pick)
    );

    // state and registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DSETS; d++) vld_q[d] <= '0;
            hit     <= 1'b0;
            hit_set <= '0;
            hit_way <= '0;
            vic_set <= '0;
            vic_way <= '0;
            vic_wb  <= 1'b0;
            vic_tag <= '0;
        end else begin
            if (inv_go) vld_q[inv_ds][inv_dw] <= 1'b0;
            if (ins_go) begin
                vld_q[ins_ds][ins_dw] <= 1'b1;
                tag_q[ins_ds][ins_dw] <= ins_tag;
            end
            hit     <= lk_hit;
            hit_set <= lk_hit ? SET_W'(dir_to_cset(uint_t'(lk_ds), uint_t'(m_idx), RSV, DSETS)) : '0;
            hit_way <= lk_hit ? WAY_W'(dir_to_cway(uint_t'(m_idx), RSV, WAYS)) : '0;
            vic_set <= vq_set;
            vic_way <= WAY_W'(RBASE + uint_t'(v_pick));
            vic_wb  <= v_full;
            vic_tag <= v_full ? sub_tag[v_pick] : '0;
        end
    end

    p_hit_group_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> (uint_t'(hit_set) % DSETS) == (uint_t'($past(lk_set)) % DSETS));

    p_hit_rsv_way_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_way >= WAY_W'(RBASE));

    p_ins_lands_r4: assert property (@(posedge clk) disable iff (rst)
        ins_go |=> vld_q[$past(ins_ds)][$past(ins_dw)]
                && tag_q[$past(ins_ds)][$past(ins_dw)] == $past(ins_tag));

    p_inv_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (inv_go && !(ins_go && ins_ds == inv_ds && ins_dw == inv_dw))
        |=> !vld_q[$past(inv_ds)][$past(inv_dw)]);
endmodule

// File: tb/tb_rpd_dir.sv
module tb_rpd_dir;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;     // 0 lookup, 1 insert, 2 invalidate
        logic [2:0]  st;
        logic [3:0]  wy;
        logic [15:0] tg;
        logic        ehit;
        logic [2:0]  eset;
        logic [3:0]  eway;
        logic [3:0]  rq;
    } vec_t;

    // default geometry: 8 sets, 16 ways, 4 reserve ways (12..15), groups of 2
    localparam vec_t VEC [12] = '{
        '{2'd1, 3'd1, 4'd13, 16'h00A1, 1'b0, 3'd0, 4'd0,  4'd4},  // R4 insert
        '{2'd0, 3'd5, 4'd0,  16'h00A1, 1'b1, 3'd1, 4'd13, 4'd2},  // R2 fellow finds it
        '{2'd0, 3'd1, 4'd0,  16'h00A1, 1'b1, 3'd1, 4'd13, 4'd3},  // R3 home finds it
        '{2'd0, 3'd2, 4'd0,  16'h00A1, 1'b0, 3'd0, 4'd0,  4'd2},  // R2 other group misses
        '{2'd1, 3'd6, 4'd15, 16'h00B2, 1'b0, 3'd0, 4'd0,  4'd4},  // R4 insert
        '{2'd0, 3'd2, 4'd0,  16'h00B2, 1'b1, 3'd6, 4'd15, 4'd3},  // R3
        '{2'd2, 3'd6, 4'd15, 16'h0000, 1'b0, 3'd0, 4'd0,  4'd5},  // R5 drop
        '{2'd0, 3'd6, 4'd0,  16'h00B2, 1'b0, 3'd0, 4'd0,  4'd5},  // R5 gone
        '{2'd1, 3'd3, 4'd5,  16'h00C3, 1'b0, 3'd0, 4'd0,  4'd6},  // R6 normal way insert
        '{2'd0, 3'd3, 4'd0,  16'h00C3, 1'b0, 3'd0, 4'd0,  4'd6},  // R6 not stored
        '{2'd2, 3'd1, 4'd5,  16'h0000, 1'b0, 3'd0, 4'd0,  4'd6},  // R6 normal way drop
        '{2'd0, 3'd5, 4'd0,  16'h00A1, 1'b1, 3'd1, 4'd13, 4'd6}   // R6 entry survives
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [2:0]  lk_set = '0;
    logic [41:0] lk_tag = '0;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_set = '0;
    logic [3:0]  ins_way = '0;
    logic [41:0] ins_tag = '0;
    logic        inv_valid = 1'b0;
    logic [2:0]  inv_set = '0;
    logic [3:0]  inv_way = '0;
    logic [2:0]  vq_set = '0;
    logic        hit;
    logic [2:0]  hit_set;
    logic [3:0]  hit_way;
    logic [2:0]  vic_set;
    logic [3:0]  vic_way;
    logic        vic_wb;
    logic [41:0] vic_tag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rpd_dir dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
        .ins_valid(ins_valid), .ins_set(ins_set), .ins_way(ins_way), .ins_tag(ins_tag),
        .inv_valid(inv_valid), .inv_set(inv_set), .inv_way(inv_way),
        .vq_set(vq_set),
        .hit(hit), .hit_set(hit_set), .hit_way(hit_way),
        .vic_set(vic_set), .vic_way(vic_way), .vic_wb(vic_wb), .vic_tag(vic_tag)
    );

    function automatic logic [41:0] tg(input logic [15:0] v);
        return {26'h2A5A5A5, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; ins_valid = 1'b0; inv_valid = 1'b0;
    endtask

    // apply current inputs for one edge, then sample at the next falling edge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic look(input logic [2:0] s, input logic [15:0] t);
        lk_valid = 1'b1; lk_set = s; lk_tag = tg(t);
    endtask

    task automatic ins(input logic [2:0] s, input logic [3:0] w, input logic [15:0] t);
        ins_valid = 1'b1; ins_set = s; ins_way = w; ins_tag = tg(t);
    endtask

    task automatic inv(input logic [2:0] s, input logic [3:0] w);
        inv_valid = 1'b1; inv_set = s; inv_way = w;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        look(3'd0, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        chk("R1 hit in reset", 64'(hit), 64'd0);
        chk("R1 vic_way in reset", 64'(vic_way), 64'd0);
        rst = 1'b0;
        vq_set = 3'd5;
        look(3'd5, 16'h0000);
        cycle();
        chk("R1 miss after reset", 64'(hit), 64'd0);
        chk("R1 victim way", 64'(vic_way), 64'd12);
        chk("R1 victim wb", 64'(vic_wb), 64'd0);
        chk("R1 victim set", 64'(vic_set), 64'd5);

        // table walk
        foreach (VEC[i]) begin
            case (VEC[i].op)
                2'd0: look(VEC[i].st, VEC[i].tg);
                2'd1: ins(VEC[i].st, VEC[i].wy, VEC[i].tg);
                default: inv(VEC[i].st, VEC[i].wy);
            endcase
            cycle();
            if (VEC[i].op == 2'd0) begin
                checks++;
                if (hit !== VEC[i].ehit || hit_set !== VEC[i].eset || hit_way !== VEC[i].eway) begin
                    errors++;
                    $display("FAIL R%0d vec %0d actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
                             VEC[i].rq, i, hit, hit_set, hit_way,
                             VEC[i].ehit, VEC[i].eset, VEC[i].eway);
                end
            end
        end

        // R7 lookup and insert in the same directory set, same cycle
        do_reset();
        look(3'd0, 16'h0077);
        ins(3'd4, 4'd12, 16'h0077);
        cycle();
        chk("R7 same-cycle lookup misses", 64'(hit), 64'd0);
        look(3'd0, 16'h0077);
        cycle();
        chk("R7 later lookup hits", 64'(hit), 64'd1);
        chk("R3 set of moved block", 64'(hit_set), 64'd4);
        chk("R3 way of moved block", 64'(hit_way), 64'd12);

        // R5 insert beats invalidate on the same slot
        ins(3'd0, 4'd14, 16'h0088);
        inv(3'd0, 4'd14);
        cycle();
        look(3'd4, 16'h0088);
        cycle();
        chk("R5 insert wins", 64'(hit), 64'd1);
        chk("R5 way", 64'(hit_way), 64'd14);

        // R8 / R9 / R10 / R11 / R4 placement and recency on set 2
        do_reset();
        vq_set = 3'd2;
        ins(3'd2, 4'd12, 16'h0100);
        cycle();
        ins(3'd2, 4'd13, 16'h0101);
        cycle();
        cycle();
        chk("R8 lowest free way", 64'(vic_way), 64'd14);
        chk("R8 no writeback", 64'(vic_wb), 64'd0);
        chk("R8 no tag", 64'(vic_tag), 64'd0);
        ins(3'd2, 4'd14, 16'h0102);
        cycle();
        ins(3'd2, 4'd15, 16'h0103);
        cycle();
        cycle();
        chk("R9 oldest way", 64'(vic_way), 64'd12);
        chk("R9 writeback", 64'(vic_wb), 64'd1);
        chk("R9 displaced tag", 64'(vic_tag), 64'(tg(16'h0100)));
        look(3'd6, 16'h0100);
        cycle();
        chk("R10 hit from fellow", 64'(hit), 64'd1);
        chk("R10 hit set", 64'(hit_set), 64'd2);
        cycle();
        chk("R10 hit refreshes", 64'(vic_way), 64'd13);
        chk("R10 displaced tag", 64'(vic_tag), 64'(tg(16'h0101)));
        lk_valid = 1'b0; lk_set = 3'd2; lk_tag = tg(16'h0101);
        cycle();
        chk("R11 no hit when idle", 64'(hit), 64'd0);
        cycle();
        chk("R11 recency unchanged", 64'(vic_way), 64'd13);
        ins(3'd2, 4'd13, 16'h0199);
        cycle();
        cycle();
        chk("R9 insert refreshes", 64'(vic_way), 64'd14);
        look(3'd2, 16'h0101);
        cycle();
        chk("R4 old tag replaced", 64'(hit), 64'd0);
        look(3'd2, 16'h0199);
        cycle();
        chk("R4 new tag found", 64'(hit), 64'd1);
        chk("R4 new tag way", 64'(hit_way), 64'd13);

        summary();
        $finish;
    end
endmodule